// File: doc/BRIEF.md
# USB Token and Data CRC Unit

This block computes and checks the two cyclic redundancy checks that USB packets carry. It works one bit at a time. A packet begins with a one-cycle `start` pulse, which loads the shift register with all ones. The same pulse samples `mode`: 0 selects the 5-bit token CRC and 1 selects the 16-bit data CRC. After that, each cycle with `bit_vld` high moves one bit into the register. Bits arrive least significant bit first, after bit stuffing has been removed and with the PID already stripped. A one-cycle `finish` pulse ends the packet.

One cycle after `finish`, the unit raises `done` for one cycle. At the same moment it presents two results. The first is the complemented CRC field, laid out in the order it goes onto the wire. The second is a residual verdict for receive use. To use that verdict, the receiver feeds the covered bits followed by the received CRC bits. The unit then reports whether the register ended at the expected residual.

Token packets cover the 11 address and endpoint bits. Data packets cover the whole payload, and the payload may be empty.

Top module: `usb_crc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `done`, `crc_field`, `crc_ok` and `crc_err` all become 0.
- R2: A `start` pulse loads the register with all ones. A zero-length data packet therefore yields `crc_field` = 0x0000.
- R3: With `mode`=0 at `start`, the register uses the generator x^5+x^2+1. For 11 covered bits, `crc_field[15:5]` is 0.
- R4: With `mode`=1 at `start`, the register uses the generator x^16+x^15+x^2+1, for any payload length including zero.
- R5: `crc_field[i]` is the ones' complement of remainder bit W-1-i, where W is 5 or 16. So bit 0 is the first bit sent and carries the complemented most significant remainder bit.
- R6: In token mode, feeding the covered bits and then the received CRC bits in wire order leaves the residual 5'b01100. That result gives `crc_ok`=1 and `crc_err`=0.
- R7: In data mode, the same procedure leaves the residual 0x800D. That result gives `crc_ok`=1 and `crc_err`=0.
- R8: If the residual differs from the value for the latched mode, then `crc_err`=1 and `crc_ok`=0. Any single flipped bit in the stream must produce this result. The two flags are never high together.
- R9: `done` is high exactly in the cycle after `finish`. `crc_field`, `crc_ok` and `crc_err` change only at that edge and hold until the next accepted `finish`.
- R10: A `finish` or `bit_vld` that arrives when no packet is open is ignored: no `done` is raised and the outputs hold.
- R11: Changes on `mode` after `start` do not affect the packet in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | CRC kind sampled at `start`: 0 token, 1 data |
| start | input | 1 | Opens a packet and presets the register |
| bit_vld | input | 1 | `bit_in` is valid this cycle |
| bit_in | input | 1 | Serial data bit, LSB first |
| finish | input | 1 | Closes the packet and captures the results |
| done | output | 1 | One-cycle pulse when results are updated |
| crc_field | output | 16 | Complemented CRC in wire order (bit 0 sent first) |
| crc_ok | output | 1 | Residual matched for the latched mode |
| crc_err | output | 1 | Residual mismatched for the latched mode |

## Verification
The assertions assume that `start`, `bit_vld` and `finish` never occur together. Each control cycle is therefore a preset, a shift or a capture, and never a mix. The bench keeps to this rule by driving every packet as a sequence. It sends a lone `start` cycle, one `bit_vld` cycle per bit, and then a lone `finish` cycle. All inputs change only on falling edges. The residual properties also assume that the mode stays latched through a packet. The bench deliberately toggles `mode` in the middle of a packet to show that this assumption holds.

// File: rtl/usb_crc_pkg.sv
// Package: shared constants and types for the USB CRC unit.
// Assumes: the polynomials are written without their top term, in the
// orientation that the left-shifting register uses.
package usb_crc_pkg;
    localparam int TOK_W = 5;
    localparam int DAT_W = 16;
    localparam logic [TOK_W-1:0] TOK_POLY = 5'h05;
    localparam logic [DAT_W-1:0] DAT_POLY = 16'h8005;
    localparam logic [TOK_W-1:0] TOK_RESID = 5'h0C;
    localparam logic [DAT_W-1:0] DAT_RESID = 16'h800D;

    typedef enum logic {
        CRC_TOKEN = 1'b0,
        CRC_DATA  = 1'b1
    } crc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } pkt_state_e;
endpackage

// File: rtl/usb_crc_ctrl.sv
// Module: usb_crc_ctrl
// Tracks whether a packet is open and latches the CRC kind at start.
// It turns the strobes into preset, shift and capture commands.
// Assumes: start, bit_vld and finish are mutually exclusive.
module usb_crc_ctrl
    import usb_crc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode,
    input  logic      start,
    input  logic      bit_vld,
    input  logic      finish,
    output logic      preset,
    output logic      shift,
    output logic      capture,
    output crc_kind_e kind
);
    pkt_state_e state_q;
    crc_kind_e  kind_q;

    // Command decode: strobes are ignored outside an open packet.
    always_comb begin
        preset  = start;
        shift   = (state_q == ST_OPEN) && bit_vld && !start;
        capture = (state_q == ST_OPEN) && finish && !start;
    end

    // Packet state and kind latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= CRC_TOKEN;
        end else if (start) begin
            state_q <= ST_OPEN;
            kind_q  <= crc_kind_e'(mode);
        end else if (capture) begin
            state_q <= ST_IDLE;
        end
    end

    assign kind = kind_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, bit_vld, finish}));                          // R9
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) && !start |=> $stable(kind_q));          // R11
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !capture && !shift);                 // R10
endmodule

// File: rtl/usb_crc_engine.sv
// Module: usb_crc_engine
// A bit-serial shift register made of XOR feedback into flip-flops.
// It runs either the token polynomial in the low TW bits or the data
// polynomial across all DW bits.
// Assumes: kind is stable for the whole packet; preset wins over shift.
module usb_crc_engine
    import usb_crc_pkg::*;
#(
    parameter int TW = TOK_W,
    parameter int DW = DAT_W,
    parameter logic [TW-1:0] TPOLY = TOK_POLY,
    parameter logic [DW-1:0] DPOLY = DAT_POLY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset,
    input  logic          shift,
    input  logic          din,
    input  crc_kind_e     kind,
    output logic [DW-1:0] crc_q
);
    localparam int PADW = DW - TW;

    logic          fb_tok, fb_dat;
    logic [TW-1:0] tok_nxt;
    logic [DW-1:0] dat_nxt;
    logic [DW-1:0] nxt;

    // Feedback bits: the incoming bit XOR the current top bit of each width.
    always_comb begin
        fb_tok = din ^ crc_q[TW-1];
        fb_dat = din ^ crc_q[DW-1];
    end

    // Per-bit next state for each polynomial.
    for (genvar i = 0; i < TW; i++) begin : g_tok
        if (i == 0) begin : g_lsb
            assign tok_nxt[i] = fb_tok & TPOLY[i];
        end else begin : g_mid
            assign tok_nxt[i] = crc_q[i-1] ^ (fb_tok & TPOLY[i]);
        end
    end

    for (genvar i = 0; i < DW; i++) begin : g_dat
        if (i == 0) begin : g_lsb
            assign dat_nxt[i] = fb_dat & DPOLY[i];
        end else begin : g_mid
            assign dat_nxt[i] = crc_q[i-1] ^ (fb_dat & DPOLY[i]);
        end
    end

    // Select the shift result for the latched kind.
    always_comb begin
        if (kind == CRC_DATA) nxt = dat_nxt;
        else                  nxt = {{PADW{1'b0}}, tok_nxt};
    end

    // Register update: preset to all ones, or shift one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '1;
        else if (preset) crc_q <= '1;
        else if (shift)  crc_q <= nxt;
    end

    AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (crc_q == {DW{1'b1}}));                            // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !preset && !shift |=> $stable(crc_q));                        // R10
    AST_TOKEN_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        shift && !preset && (kind == CRC_TOKEN) |=> (crc_q[DW-1:TW] == '0)); // R3
endmodule

// File: rtl/usb_crc_result.sv
// Module: usb_crc_result
// Captures the wire-order complemented CRC field and the residual
// verdict when a packet closes, and pulses done for one cycle.
// Assumes: the capture command arrives with a register value that is
// settled for the latched kind.
module usb_crc_result
    import usb_crc_pkg::*;
#(
    parameter int TW = TOK_W,
    parameter int DW = DAT_W,
    parameter logic [TW-1:0] TRES = TOK_RESID,
    parameter logic [DW-1:0] DRES = DAT_RESID
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  crc_kind_e     kind,
    input  logic [DW-1:0] crc_q,
    output logic          done,
    output logic [DW-1:0] field,
    output logic          ok,
    output logic          err
);
    localparam int PADW = DW - TW;

    logic [TW-1:0] tok_field;
    logic [DW-1:0] dat_field;
    logic [DW-1:0] field_nxt;
    logic          match;

    // Reverse and complement the remainder into first-sent-first order.
    for (genvar i = 0; i < TW; i++) begin : g_tf
        assign tok_field[i] = ~crc_q[TW-1-i];
    end
    for (genvar i = 0; i < DW; i++) begin : g_df
        assign dat_field[i] = ~crc_q[DW-1-i];
    end

    // Pick the field and the residual comparison for the latched kind.
    always_comb begin
        if (kind == CRC_DATA) begin
            field_nxt = dat_field;
            match     = (crc_q == DRES);
        end else begin
            field_nxt = {{PADW{1'b0}}, tok_field};
            match     = (crc_q[TW-1:0] == TRES);
        end
    end

    // Result registers, written only on capture; done is a single pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            field <= '0;
            ok    <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= capture;
            if (capture) begin
                field <= field_nxt;
                ok    <= match;
                err   <= !match;
            end
        end
    end

    AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done);                                            // R9
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(field) && $stable(ok) && $stable(err));  // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));                                                // R8
endmodule

// File: rtl/usb_crc_unit.sv
// Module: usb_crc_unit (top)
// Bit-serial USB CRC5/CRC16 generator and checker built from a control
// tracker, a shared shift engine and a result stage.
// Assumes: serial bits arrive LSB first with stuffing removed and the
// PID excluded; the control strobes are mutually exclusive.
module usb_crc_unit
    import usb_crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode,
    input  logic        start,
    input  logic        bit_vld,
    input  logic        bit_in,
    input  logic        finish,
    output logic        done,
    output logic [15:0] crc_field,
    output logic        crc_ok,
    output logic        crc_err
);
    logic             preset, shift, capture;
    crc_kind_e        kind;
    logic [DAT_W-1:0] crc_q;

    usb_crc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .start   (start),
        .bit_vld (bit_vld),
        .finish  (finish),
        .preset  (preset),
        .shift   (shift),
        .capture (capture),
        .kind    (kind)
    );

    usb_crc_engine u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (preset),
        .shift  (shift),
        .din    (bit_in),
        .kind   (kind),
        .crc_q  (crc_q)
    );

    usb_crc_result u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .kind    (kind),
        .crc_q   (crc_q),
        .done    (done),
        .field   (crc_field),
        .ok      (crc_ok),
        .err     (crc_err)
    );

    AST_DONE_NEEDS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(finish));                               // R10
    AST_VERDICT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (crc_ok != crc_err));                                // R8
endmodule

// File: tb/tb_usb_crc_unit.sv
module tb_usb_crc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0, start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, finish = 1'b0;
    logic        done, crc_ok, crc_err;
    logic [15:0] crc_field;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_crc_unit dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .bit_vld(bit_vld),
        .bit_in(bit_in), .finish(finish), .done(done), .crc_field(crc_field),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    task automatic chk(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: remainder by long division, preset all ones, then wire-order complement.
    function automatic logic [15:0] ref_field(input bit data, input logic [127:0] msg, input int n);
        int w = data ? 16 : 5;
        logic [15:0] g = data ? 16'h8005 : 16'h0005;
        logic [15:0] r = data ? 16'hFFFF : 16'h001F;
        logic [15:0] f = '0;
        for (int i = 0; i < n; i++) begin
            logic top = r[w-1];
            r = (r << 1) & ((16'h1 << w) - 1'b1) ^ (16'h0);
            r[15:0] = r & ((w == 16) ? 16'hFFFF : 16'h001F);
            if (top ^ msg[i]) r = r ^ g;
        end
        for (int i = 0; i < w; i++) f[i] = ~r[w-1-i];
        return f;
    endfunction

    // Drive one packet; results are sampled on return, one cycle after finish.
    task automatic send(input bit data, input logic [127:0] msg, input int n, input bit flip_mode);
        @(negedge clk); mode = data; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_vld = 1'b1; bit_in = msg[i];
            if (flip_mode) mode = ~mode;
            @(negedge clk);
        end
        bit_vld = 1'b0; bit_in = 1'b0; finish = 1'b1;
        @(negedge clk); finish = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] m;
        logic [15:0]  e, f0;
        logic [31:0]  lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && crc_field == 0 && !crc_ok && !crc_err, "R1", {crc_ok, crc_err, crc_field}, 0);
        rst_n = 1'b1;

        // R2: zero-length data packet gives 0x0000
        send(1'b1, '0, 0, 1'b0);
        chk(crc_field == 16'h0000 && done, "R2", crc_field, 16'h0000);

        // R3 R5 R6 R8: exhaustive token sweep over all 11-bit address+endpoint values
        for (int v = 0; v < 2048; v++) begin
            m = '0; m[10:0] = v[10:0];
            e = ref_field(1'b0, m, 11);
            send(1'b0, m, 11, 1'b0);
            chk(crc_field == e, "R3/R5 token field", crc_field, e);
            chk(crc_field[15:5] == 0, "R3 upper zero", crc_field, e);
            m[15:11] = e[4:0];
            if (v % 64 == 7) begin
                m[v % 16] = ~m[v % 16];
                send(1'b0, m, 16, 1'b0);
                chk(crc_err && !crc_ok, "R8 token flip", {crc_ok, crc_err}, 2'b01);
            end else begin
                send(1'b0, m, 16, 1'b0);
                chk(crc_ok && !crc_err, "R6 token residual", {crc_ok, crc_err}, 2'b10);
            end
        end

        // R4 R7: data payloads of 0..8 bytes
        for (int len = 0; len <= 8; len++) begin
            for (int k = 0; k < 12; k++) begin
                m = '0;
                for (int b = 0; b < len * 8; b++) begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    m[b] = lfsr[0];
                end
                e = ref_field(1'b1, m, len * 8);
                send(1'b1, m, len * 8, 1'b0);
                chk(crc_field == e, "R4/R5 data field", crc_field, e);
                for (int b = 0; b < 16; b++) m[len * 8 + b] = e[b];
                send(1'b1, m, len * 8 + 16, 1'b0);
                chk(crc_ok && !crc_err, "R7 data residual", {crc_ok, crc_err}, 2'b10);
            end
        end

        // R8: every single-bit flip in a 4-byte packet plus CRC
        m = 128'h0;
        m[31:0] = 32'hC3A5_1E70;
        e = ref_field(1'b1, m, 32);
        m[47:32] = e;
        for (int p = 0; p < 48; p++) begin
            logic [127:0] c = m;
            c[p] = ~c[p];
            send(1'b1, c, 48, 1'b0);
            chk(crc_err && !crc_ok, "R8 data flip", {crc_ok, crc_err}, 2'b01);
        end

        // R9: done lasts one cycle, outputs hold afterwards
        m = '0; m[15:0] = 16'h00A5;
        e = ref_field(1'b1, m, 16);
        send(1'b1, m, 16, 1'b0);
        chk(done == 1'b1, "R9 done pulse", done, 1);
        f0 = crc_field;
        @(negedge clk);
        chk(done == 1'b0 && crc_field == f0, "R9 hold", {done, crc_field}, {1'b0, f0});

        // R10: finish and bits while idle are ignored
        bit_vld = 1'b1; bit_in = 1'b1; @(negedge clk); bit_vld = 1'b0;
        finish = 1'b1; @(negedge clk); finish = 1'b0;
        chk(done == 1'b0 && crc_field == f0, "R10 idle finish", {done, crc_field}, {1'b0, f0});
        @(negedge clk);
        chk(done == 1'b0 && crc_field == e, "R10 outputs held", crc_field, e);

        // R11: toggling mode mid-packet leaves the data CRC unchanged
        m = '0; m[23:0] = 24'h5A_0F3C;
        e = ref_field(1'b1, m, 24);
        send(1'b1, m, 24, 1'b1);
        chk(crc_field == e, "R11 mode held", crc_field, e);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule